// File: doc/BRIEF.md
# Ethernet Receive Error Statistics Counters

This block sorts every received Ethernet frame into receive error categories and keeps a saturating 12-bit counter for each one. The receive MAC supplies a one-cycle status strobe for each frame. The strobe carries the byte length and five flags: checksum good, dribble bits present, VLAN tag present, truncated at the maximum frame length, and invalid data symbol seen. From these the block decides which counters to bump.

In parallel, the block watches the MII receive pins while the line is idle. It latches a false-carrier event there and adds it to the carrier counter only when the next frame status arrives. Software reads or loads any counter through a small indexed register port. Read data is zero-extended to 32 bits.

Top module: `rx_err_stats`

## Requirements
- R1: After reset every counter reads 0. Bits 31:12 of `reg_rdata` read 0 at all times.
- R2: Index 0 (alignment) increments for a reported frame with length 64 to 1518 inclusive, a bad checksum and dribble bits set.
- R3: Index 1 (code) increments for every reported frame whose invalid-symbol flag is set.
- R4: A false carrier is an idle cycle (`mii_rx_dv`=0) with `mii_rx_er`=1 and `mii_rxd`=4'hE. No other combination is a false carrier, including the same pin values while `mii_rx_dv`=1.
- R5: A false carrier does not change index 2 (carrier) by itself. Index 2 increments by exactly one on the next frame report, however many events occurred in the gap. An event in the same cycle as a report is held for the following report.
- R6: Index 3 (undersize) increments for a frame shorter than 64 bytes that has a good checksum, no dribble bits and no invalid symbol.
- R7: Index 4 (oversize) increments for a frame with a good checksum, no dribble bits and no invalid symbol, whose length exceeds 1518, or exceeds 1522 when the VLAN flag is set.
- R8: A frame with the truncation flag set never increments index 4.
- R9: Index 5 (fragments) increments for a frame shorter than 64 bytes with a bad checksum, whether or not dribble bits are present.
- R10: `reg_rdata[11:0]` shows the counter selected by `reg_idx` (0 to 5) in the same cycle. Indices 6 and 7 read 0, and writes to them change nothing.
- R11: A counter at 12'hFFF stays at 12'hFFF when it would increment.
- R12: A write with `reg_we`=1 loads `reg_wdata` into the selected counter on the next clock edge. The write takes priority over an increment of that counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_rx_dv | input | 1 | MII receive data valid |
| mii_rx_er | input | 1 | MII receive error |
| mii_rxd | input | 4 | MII receive data nibble |
| fs_valid | input | 1 | One-cycle frame status strobe |
| fs_len | input | 16 | Frame length in bytes |
| fs_fcs_ok | input | 1 | Frame checksum good |
| fs_dribble | input | 1 | Non-integral byte count |
| fs_vlan | input | 1 | Frame carries a VLAN tag |
| fs_trunc | input | 1 | Frame truncated at maximum length |
| fs_badsym | input | 1 | Invalid data symbol seen with carrier |
| reg_idx | input | 3 | Counter index |
| reg_we | input | 1 | Counter write enable |
| reg_wdata | input | 12 | Counter write value |
| reg_rdata | output | 32 | Selected counter, zero-extended |

## Verification
A software load and a frame-driven increment can hit the same counter in one cycle. The bench provokes this by asserting `reg_we` on the alignment index while a frame that qualifies as an alignment error is strobed. The loaded value must then be read back unchanged.

A second collision occurs when an idle false carrier coincides with a frame report. The bench places an event exactly on the strobe cycle. It judges the outcome by checking that the carrier counter does not move on that report but does move on the following one. The behavioural model is compared with the read port on every clock throughout.

// File: rtl/rxes_pkg.sv
package rxes_pkg;
   localparam int NUM_STATS = 6;

   typedef enum logic [2:0] {
      IDX_ALIGN = 3'd0,
      IDX_CODE  = 3'd1,
      IDX_FCAR  = 3'd2,
      IDX_UNDER = 3'd3,
      IDX_OVER  = 3'd4,
      IDX_FRAG  = 3'd5
   } stat_idx_e;

   typedef struct packed {
      logic fcs_ok;
      logic dribble;
      logic vlan;
      logic trunc;
      logic badsym;
   } frame_flags_t;
endpackage

// File: rtl/rxes_classify.sv
module rxes_classify
   import rxes_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int MIN_LEN  = 64,
   parameter int MAX_STD  = 1518,
   parameter int MAX_VLAN = 1522
) (
   input  logic                 valid,
   input  logic [LEN_W-1:0]     len,
   input  frame_flags_t         flags,
   input  logic                 fcar_pending,
   output logic [NUM_STATS-1:0] bump
);
   localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] STD_L  = LEN_W'(MAX_STD);
   localparam logic [LEN_W-1:0] VLAN_L = LEN_W'(MAX_VLAN);

   logic             is_short, in_range, is_long, clean;
   logic [LEN_W-1:0] limit;

   always_comb begin
      limit    = flags.vlan ? VLAN_L : STD_L;
      is_short = len < MIN_L;
      in_range = (len >= MIN_L) && (len <= STD_L);
      is_long  = len > limit;
      clean    = !flags.dribble && !flags.badsym;

      bump            = '0;
      bump[IDX_ALIGN] = valid && in_range && !flags.fcs_ok && flags.dribble;
      bump[IDX_CODE]  = valid && flags.badsym;
      bump[IDX_FCAR]  = valid && fcar_pending;
      bump[IDX_UNDER] = valid && is_short && flags.fcs_ok && clean;
      bump[IDX_OVER]  = valid && is_long && flags.fcs_ok && clean && !flags.trunc;
      bump[IDX_FRAG]  = valid && is_short && !flags.fcs_ok;
   end
endmodule

// File: rtl/rxes_fcar.sv
module rxes_fcar #(
   parameter int         DW      = 4,
   parameter logic [3:0] FC_CODE = 4'hE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_dv,
   input  logic          rx_er,
   input  logic [DW-1:0] rxd,
   input  logic          report,
   output logic          pending
);
   logic ev;

   assign ev = !rx_dv && rx_er && (rxd == DW'(FC_CODE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pending <= 1'b0;
      else if (report) pending <= ev;
      else             pending <= pending | ev;
   end
endmodule

// File: rtl/rxes_counter.sv
module rxes_counter #(
   parameter int CNT_W    = 12,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             inc,
   output logic [CNT_W-1:0] q
);
   localparam logic [CNT_W-1:0] TOP = '1;
   logic step;

   generate
      if (SATURATE) begin : g_sat
         assign step = inc && (q != TOP);
      end else begin : g_wrap
         assign step = inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (ld)   q <= ld_val;
      else if (step) q <= q + CNT_W'(1);
   end
endmodule

// File: rtl/rx_err_stats.sv
module rx_err_stats
   import rxes_pkg::*;
#(
   parameter int CNT_W    = 12,
   parameter int LEN_W    = 16,
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 3,
   parameter int MIN_LEN  = 64,
   parameter int MAX_STD  = 1518,
   parameter int MAX_VLAN = 1522,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mii_rx_dv,
   input  logic              mii_rx_er,
   input  logic [3:0]        mii_rxd,
   input  logic              fs_valid,
   input  logic [LEN_W-1:0]  fs_len,
   input  logic              fs_fcs_ok,
   input  logic              fs_dribble,
   input  logic              fs_vlan,
   input  logic              fs_trunc,
   input  logic              fs_badsym,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic              reg_we,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);
   generate
      if (CNT_W > DATA_W)        begin : g_e1 $error("CNT_W wider than DATA_W"); end
      if (MAX_VLAN < MAX_STD)    begin : g_e2 $error("VLAN limit below plain limit"); end
      if ((1 << IDX_W) < NUM_STATS) begin : g_e3 $error("IDX_W too narrow"); end
      if (MAX_VLAN >= (1 << LEN_W)) begin : g_e4 $error("LEN_W too narrow"); end
   endgenerate

   frame_flags_t         flags;
   logic                 pending;
   logic [NUM_STATS-1:0] bump;
   logic [CNT_W-1:0]     cnt_q [NUM_STATS];

   assign flags = '{fcs_ok: fs_fcs_ok, dribble: fs_dribble, vlan: fs_vlan,
                    trunc: fs_trunc, badsym: fs_badsym};

   rxes_fcar #(.DW(4), .FC_CODE(4'hE)) u_fcar (
      .clk(clk), .rst_n(rst_n), .rx_dv(mii_rx_dv), .rx_er(mii_rx_er),
      .rxd(mii_rxd), .report(fs_valid), .pending(pending)
   );

   rxes_classify #(
      .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_STD(MAX_STD), .MAX_VLAN(MAX_VLAN)
   ) u_cls (
      .valid(fs_valid), .len(fs_len), .flags(flags),
      .fcar_pending(pending), .bump(bump)
   );

   genvar k;
   generate
      for (k = 0; k < NUM_STATS; k++) begin : g_cnt
         logic sel;
         assign sel = reg_we && (reg_idx == IDX_W'(k));
         rxes_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_c (
            .clk(clk), .rst_n(rst_n), .ld(sel), .ld_val(reg_wdata),
            .inc(bump[k]), .q(cnt_q[k])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_STATS; i++)
         if (reg_idx == IDX_W'(i)) reg_rdata[CNT_W-1:0] = cnt_q[i];
   end
endmodule

// File: rtl/rxes_checker.sv
module rxes_checker #(
   parameter int CNT_W    = 12,
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 3,
   parameter bit SATURATE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fs_valid,
   input logic [IDX_W-1:0]  reg_idx,
   input logic              reg_we,
   input logic [CNT_W-1:0]  reg_wdata,
   input logic [DATA_W-1:0] reg_rdata
);
   localparam int NUM = rxes_pkg::NUM_STATS;

   assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:CNT_W] == '0);

   assert_spare_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(reg_idx) >= NUM) |-> (reg_rdata == '0));

   assert_write_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && 32'(reg_idx) < NUM) |=>
         ((reg_idx != $past(reg_idx)) || (reg_rdata[CNT_W-1:0] == $past(reg_wdata))));

   assert_no_report_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we && !fs_valid) |=> ((reg_idx != $past(reg_idx)) || $stable(reg_rdata)));

   generate
      if (SATURATE) begin : g_sat_chk
         assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!reg_we) |=> ((reg_idx != $past(reg_idx)) || (reg_rdata >= $past(reg_rdata))));
      end
   endgenerate
endmodule

bind rx_err_stats rxes_checker #(
   .CNT_W(CNT_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .SATURATE(SATURATE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fs_valid(fs_valid), .reg_idx(reg_idx),
   .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/sim_rx_err_stats.sv
module sim_rx_err_stats;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        mii_rx_dv = 0, mii_rx_er = 0;
   logic [3:0]  mii_rxd = 0;
   logic        fs_valid = 0, fs_fcs_ok = 0, fs_dribble = 0, fs_vlan = 0, fs_trunc = 0, fs_badsym = 0;
   logic [15:0] fs_len = 0;
   logic [2:0]  reg_idx = 0;
   logic        reg_we = 0;
   logic [11:0] reg_wdata = 0;
   logic [31:0] reg_rdata;

   int n_chk = 0, n_fail = 0;
   int m [6];
   bit m_pend = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_err_stats u0 (.*);

   // Behavioural reference, updated at each rising edge from the inputs.
   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m[i]) m[i] = 0;
         m_pend = 0;
      end else begin
         bit ev, sh, cl;
         int inc [6];
         int lim;
         ev  = !mii_rx_dv && mii_rx_er && mii_rxd == 4'hE;
         sh  = fs_len < 64;
         cl  = !fs_dribble && !fs_badsym;
         lim = fs_vlan ? 1522 : 1518;
         foreach (inc[i]) inc[i] = 0;
         if (fs_valid) begin
            inc[0] = (fs_len >= 64 && fs_len <= 1518 && !fs_fcs_ok && fs_dribble);
            inc[1] = fs_badsym;
            inc[2] = m_pend;
            inc[3] = (sh && fs_fcs_ok && cl);
            inc[4] = (int'(fs_len) > lim && fs_fcs_ok && cl && !fs_trunc);
            inc[5] = (sh && !fs_fcs_ok);
            m_pend = ev;
         end else if (ev) m_pend = 1;
         for (int i = 0; i < 6; i++) begin
            if (reg_we && reg_idx == i) m[i] = reg_wdata;
            else if (inc[i] != 0 && m[i] < 4095) m[i] = m[i] + 1;
         end
      end
   end

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-clock comparison against the model.
   always @(negedge clk) if (rst_n) begin
      check("R10", int'(reg_rdata), (reg_idx < 6) ? m[reg_idx] : 0);
      check("R1", int'(reg_rdata[31:12]), 0);
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic frame(int len, bit ok, bit dr, bit vl, bit tr, bit bs);
      step();
      fs_len = 16'(len); fs_fcs_ok = ok; fs_dribble = dr; fs_vlan = vl;
      fs_trunc = tr; fs_badsym = bs; fs_valid = 1;
      step();
      fs_valid = 0;
   endtask

   task automatic read(int idx, output int v);
      step();
      reg_idx = 3'(idx);
      @(negedge clk);
      v = int'(reg_rdata);
   endtask

   task automatic expect_cnt(string req, int idx, int exp);
      int v;
      read(idx, v);
      check(req, v, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int b, v;
      repeat (3) step();
      rst_n = 1;
      for (int i = 0; i < 8; i++) expect_cnt("R1", i, 0);

      // Alignment (R2)
      frame(100, 0, 1, 0, 0, 0);  expect_cnt("R2", 0, 1);
      frame(1518, 0, 1, 0, 0, 0); expect_cnt("R2", 0, 2);
      frame(1519, 0, 1, 0, 0, 0); expect_cnt("R2", 0, 2);
      frame(100, 0, 0, 0, 0, 0);  expect_cnt("R2", 0, 2);
      // Fragments (R9)
      frame(63, 0, 1, 0, 0, 0);   expect_cnt("R9", 5, 1);
      expect_cnt("R2", 0, 2);
      frame(10, 0, 0, 0, 0, 0);   expect_cnt("R9", 5, 2);
      // Code (R3)
      frame(100, 1, 0, 0, 0, 1);  expect_cnt("R3", 1, 1);
      // Undersize (R6)
      frame(63, 1, 0, 0, 0, 0);   expect_cnt("R6", 3, 1);
      frame(64, 1, 0, 0, 0, 0);   expect_cnt("R6", 3, 1);
      frame(40, 1, 1, 0, 0, 0);   expect_cnt("R6", 3, 1);
      // Oversize (R7, R8)
      frame(1519, 1, 0, 0, 0, 0); expect_cnt("R7", 4, 1);
      frame(1519, 1, 0, 1, 0, 0); expect_cnt("R7", 4, 1);
      frame(1522, 1, 0, 1, 0, 0); expect_cnt("R7", 4, 1);
      frame(1523, 1, 0, 1, 0, 0); expect_cnt("R7", 4, 2);
      frame(2000, 1, 0, 0, 1, 0); expect_cnt("R8", 4, 2);

      // False carrier (R4, R5)
      read(2, b);
      step(); mii_rx_er = 1; mii_rxd = 4'hE; mii_rx_dv = 1;
      step(); step(); mii_rx_dv = 0; mii_rxd = 4'hD;
      step(); step(); mii_rx_er = 0; mii_rxd = 0;
      frame(100, 1, 0, 0, 0, 0);  expect_cnt("R4", 2, b);
      step(); mii_rx_er = 1; mii_rxd = 4'hE;
      step(); step(); step(); mii_rx_er = 0; mii_rxd = 0;
      expect_cnt("R5", 2, b);
      frame(100, 1, 0, 0, 0, 0);  expect_cnt("R5", 2, b + 1);
      // Event on the report cycle goes to the next report
      step();
      fs_len = 100; fs_fcs_ok = 1; fs_dribble = 0; fs_vlan = 0; fs_trunc = 0; fs_badsym = 0;
      fs_valid = 1; mii_rx_er = 1; mii_rxd = 4'hE;
      step(); fs_valid = 0; mii_rx_er = 0; mii_rxd = 0;
      expect_cnt("R5", 2, b + 1);
      frame(100, 1, 0, 0, 0, 0);  expect_cnt("R5", 2, b + 2);

      // Write priority (R12)
      step(); reg_idx = 0; reg_we = 1; reg_wdata = 12'h005;
      fs_len = 200; fs_fcs_ok = 0; fs_dribble = 1; fs_valid = 1;
      step(); reg_we = 0; fs_valid = 0;
      expect_cnt("R12", 0, 5);
      // Saturation (R11)
      step(); reg_idx = 4; reg_we = 1; reg_wdata = 12'hFFE;
      step(); reg_we = 0;
      frame(1600, 1, 0, 0, 0, 0); expect_cnt("R11", 4, 12'hFFF);
      frame(1600, 1, 0, 0, 0, 0); expect_cnt("R11", 4, 12'hFFF);
      // Spare index (R10)
      step(); reg_idx = 6; reg_we = 1; reg_wdata = 12'hABC;
      step(); reg_we = 0;
      expect_cnt("R10", 6, 0);
      for (int i = 0; i < 6; i++) begin
         read(i, v);
         check("R10", v, m[i]);
      end
      step();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule